// File: doc/BRIEF.md
# PLL Power-Up and Retune Sequencer

This block owns the three mode-control lines of a frequency-synthesis PLL and moves them through a fixed, timed order. The three lines are an output enable, an active-low bypass and an active-low reset. A simple command port accepts three requests: switch on, switch off, and retune to a new output rate. Each command is a one-cycle `cmd_valid` pulse with an opcode and a rate.

To switch on, the block first releases bypass. It then lets the loop settle for a fixed time and releases reset. Next it waits for lock and enables the output last. Lock comes either from a lock-status input or, when the build has no such input, from a fixed wait. A retune works out the integer multiplier from the requested rate and the reference rate, and picks the high or low VCO band. When the PLL is running, a retune drops all three lines, writes the new values and runs the full power-up again.

The one-time programming of the M, N, config and droop values happens on the first power-up only. At reset the block also checks the mode state it inherits: a PLL that shows fully on but reports no lock is switched off and programmed.

Top module: `pll_mode_sequencer`

## Requirements
- R1: `mode_out` bit 0 is output enable, bit 1 is bypass release and bit 2 is reset release. On power-up, bit 1 is set first, and bit 2 is set exactly SETTLE_US*CYC_PER_US clock cycles later.
- R2: With a lock input (HAS_LOCK=1), bit 0 is set in the clock edge that first samples `lock_in` high during the lock wait, and never while `lock_in` was low. Bit 0 is always the last of the three bits to be set.
- R3: Without a lock input (HAS_LOCK=0), bit 0 is set exactly LOCK_US*CYC_PER_US cycles after bit 2.
- R4: Switch-off (opcode 2) clears all three mode bits in the same clock edge.
- R5: `pll_on` is high exactly when all three mode bits are set.
- R6: Switch-on (opcode 1) is ignored when any mode bit is set. Mode, busy and multiplier stay unchanged.
- R7: The first switch-on sets `m_out` to 0, `n_out` to 1, loads `cfg_out` and `droop_out`, and raises `cfg_done`. This costs one extra cycle before bypass release (3 cycles from the command instead of 2). Later switch-ons skip this step.
- R8: Retune (opcode 3) sets `l_out` to floor(`cmd_rate`/REF_RATE). It sets `vco_hi` to 1 only when `cmd_rate` is greater than LOW_VCO_MAX.
- R9: A retune while `pll_on` is high clears the mode bits in the same edge that updates `l_out`, then reruns the power-up sequence to fully on. A retune while not fully on leaves the mode bits unchanged and does not raise busy.
- R10: After reset, if `boot_mode` is 3'b111 and `lock_in` is low (HAS_LOCK=1), the mode bits are cleared and the one-time programming runs. If `lock_in` is high, the PLL is left fully on with no programming.
- R11: If lock does not arrive within LOCK_WDOG_CYC cycles of reset release, the mode bits are cleared, `lock_err` is raised and busy falls. The next accepted command clears `lock_err`.
- R12: `busy` is high from the cycle after an accepted switch-on or running retune until the sequence ends. Commands that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 3 | Mode-bit state inherited at reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 1 switch on, 2 switch off, 3 retune |
| cmd_rate | input | RATE_W | Requested output rate for retune |
| lock_in | input | 1 | PLL lock status |
| mode_out | output | 3 | Reset release, bypass release, output enable |
| pll_on | output | 1 | All three mode bits set |
| busy | output | 1 | Sequence in progress |
| lock_err | output | 1 | Lock watchdog expired |
| l_out | output | L_W | Integer multiplier |
| vco_hi | output | 1 | High VCO band select |
| m_out | output | MN_W | Fractional numerator value |
| n_out | output | MN_W | Fractional denominator value |
| cfg_out | output | CFG_W | Configuration word |
| droop_out | output | CFG_W | Droop-control word |
| cfg_done | output | 1 | One-time programming done |

## Verification
A wrong sequencer state shows up at `mode_out` within one clock. A skipped settle state or a misloaded timer moves the rise of reset release by a whole number of cycles, which the bench counts exactly. A state that wrongly retains the lock wait shows up as an output enable while `lock_in` is low, or as a missing `lock_err` a watchdog period later. A lost or stuck programming flag changes the command-to-bypass latency by one cycle on the second switch-on.

// File: rtl/pll_seq_pkg.sv
// Package: shared opcodes, sequencer states and mode-bit positions.
// Assumes: mode-bit positions are fixed by the PLL's control decode.
package pll_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_ON     = 2'd1,
        OP_OFF    = 2'd2,
        OP_RETUNE = 2'd3
    } pll_op_e;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_CONFIG,
        ST_BYP_REL,
        ST_SETTLE,
        ST_LOCK_WAIT
    } seq_state_e;

    localparam int          MB_OUT_EN  = 0;
    localparam int          MB_BYP_REL = 1;
    localparam int          MB_RST_REL = 2;
    localparam logic [2:0]  MODE_FULL  = 3'b111;
    localparam logic [2:0]  MODE_OFF   = 3'b000;

endpackage

// File: rtl/pll_seq_timer.sv
// Module: down-counting delay timer.
// Loads a value and counts to zero; expired is high while the count is zero.
// Assumes: load has priority over counting.
module pll_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load or decrement the count, holding at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag straight from the count.
    always_comb begin
        expired = (cnt_q == '0);
    end
endmodule

// File: rtl/pll_seq_ratecalc.sv
// Module: multiplier and VCO-band calculation for a requested rate.
// Assumes: REF_RATE is a nonzero constant and L_W <= RATE_W.
module pll_seq_ratecalc #(
    parameter int RATE_W      = 16,
    parameter int L_W         = 8,
    parameter int REF_RATE    = 25,
    parameter int LOW_VCO_MAX = 1000
) (
    input  logic [RATE_W-1:0] rate,
    output logic [L_W-1:0]    l_val,
    output logic              vco_hi
);
    logic [RATE_W-1:0] quot;

    // Integer multiplier by constant division; band by threshold compare.
    always_comb begin
        quot   = rate / RATE_W'(REF_RATE);
        l_val  = quot[L_W-1:0];
        vco_hi = (rate > RATE_W'(LOW_VCO_MAX));
    end
endmodule

// File: rtl/pll_mode_sequencer.sv
// Module: PLL mode-line sequencer (top).
// Drives bypass release, settle, reset release, lock wait and output enable
// in order; forces full power-down and relock around multiplier changes.
// Assumes: commands are single-cycle pulses; commands while busy are dropped.
module pll_mode_sequencer
    import pll_seq_pkg::*;
#(
    parameter int          CYC_PER_US    = 2,
    parameter int          SETTLE_US     = 10,
    parameter int          LOCK_US       = 60,
    parameter int          LOCK_WDOG_CYC = 400,
    parameter bit          HAS_LOCK      = 1'b1,
    parameter int          RATE_W        = 16,
    parameter int          L_W           = 8,
    parameter int          REF_RATE      = 25,
    parameter int          LOW_VCO_MAX   = 1000,
    parameter int          MN_W          = 8,
    parameter int          CFG_W         = 16,
    parameter logic [15:0] CFG_VAL       = 16'h0A5C,
    parameter logic [15:0] DROOP_VAL     = 16'h0108
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        boot_mode,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [RATE_W-1:0] cmd_rate,
    input  logic              lock_in,
    output logic [2:0]        mode_out,
    output logic              pll_on,
    output logic              busy,
    output logic              lock_err,
    output logic [L_W-1:0]    l_out,
    output logic              vco_hi,
    output logic [MN_W-1:0]   m_out,
    output logic [MN_W-1:0]   n_out,
    output logic [CFG_W-1:0]  cfg_out,
    output logic [CFG_W-1:0]  droop_out,
    output logic              cfg_done
);
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int LOCK_CYC   = LOCK_US * CYC_PER_US;
    localparam int WAIT_CYC   = HAS_LOCK ? LOCK_WDOG_CYC : LOCK_CYC;
    localparam int TMR_MAX    = (SETTLE_CYC > WAIT_CYC) ? SETTLE_CYC : WAIT_CYC;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);

    seq_state_e        state_q;
    logic [2:0]        mode_q;
    logic              seq_after_cfg_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [L_W-1:0]    calc_l;
    logic              calc_vco;
    pll_op_e           op;

    pll_seq_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    pll_seq_ratecalc #(
        .RATE_W      (RATE_W),
        .L_W         (L_W),
        .REF_RATE    (REF_RATE),
        .LOW_VCO_MAX (LOW_VCO_MAX)
    ) u_rate (
        .rate   (cmd_rate),
        .l_val  (calc_l),
        .vco_hi (calc_vco)
    );

    // Decode the opcode and pick the timer load for the current phase.
    always_comb begin
        op       = pll_op_e'(cmd_op);
        tmr_load = (state_q == ST_BYP_REL) || (state_q == ST_SETTLE && tmr_exp);
        tmr_val  = (state_q == ST_BYP_REL) ? TMR_W'(SETTLE_CYC - 1)
                                           : TMR_W'(WAIT_CYC - 1);
    end

    // Sequencer: command acceptance, one-time programming and mode ordering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= ST_BOOT;
            mode_q          <= boot_mode;
            seq_after_cfg_q <= 1'b0;
            lock_err        <= 1'b0;
            l_out           <= '0;
            vco_hi          <= 1'b0;
            m_out           <= '1;
            n_out           <= '0;
            cfg_out         <= '0;
            droop_out       <= '0;
            cfg_done        <= 1'b0;
        end else begin
            case (state_q)
                ST_BOOT: begin
                    if (HAS_LOCK && mode_q == MODE_FULL && !lock_in) begin
                        mode_q          <= MODE_OFF;
                        seq_after_cfg_q <= 1'b0;
                        state_q         <= ST_CONFIG;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (op)
                            OP_ON: begin
                                if (mode_q == MODE_OFF) begin
                                    lock_err        <= 1'b0;
                                    seq_after_cfg_q <= 1'b1;
                                    state_q <= cfg_done ? ST_BYP_REL : ST_CONFIG;
                                end
                            end
                            OP_OFF: begin
                                mode_q   <= MODE_OFF;
                                lock_err <= 1'b0;
                            end
                            OP_RETUNE: begin
                                l_out    <= calc_l;
                                vco_hi   <= calc_vco;
                                lock_err <= 1'b0;
                                if (mode_q == MODE_FULL) begin
                                    mode_q          <= MODE_OFF;
                                    seq_after_cfg_q <= 1'b1;
                                    state_q <= cfg_done ? ST_BYP_REL : ST_CONFIG;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_CONFIG: begin
                    m_out     <= '0;
                    n_out     <= MN_W'(1);
                    cfg_out   <= CFG_W'(CFG_VAL);
                    droop_out <= CFG_W'(DROOP_VAL);
                    cfg_done  <= 1'b1;
                    state_q   <= seq_after_cfg_q ? ST_BYP_REL : ST_IDLE;
                end
                ST_BYP_REL: begin
                    mode_q[MB_BYP_REL] <= 1'b1;
                    state_q            <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_exp) begin
                        mode_q[MB_RST_REL] <= 1'b1;
                        state_q            <= ST_LOCK_WAIT;
                    end
                end
                ST_LOCK_WAIT: begin
                    if (HAS_LOCK) begin
                        if (lock_in) begin
                            mode_q[MB_OUT_EN] <= 1'b1;
                            state_q           <= ST_IDLE;
                        end else if (tmr_exp) begin
                            mode_q   <= MODE_OFF;
                            lock_err <= 1'b1;
                            state_q  <= ST_IDLE;
                        end
                    end else if (tmr_exp) begin
                        mode_q[MB_OUT_EN] <= 1'b1;
                        state_q           <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port views of the mode register and sequencer activity.
    always_comb begin
        mode_out = mode_q;
        pll_on   = (mode_q == MODE_FULL);
        busy     = !(state_q == ST_IDLE || state_q == ST_BOOT);
    end
endmodule

// File: rtl/pll_seq_chk.sv
// Module: property checker for the PLL mode sequencer, bound to every instance.
// Assumes: observes top-level ports only.
module pll_seq_chk #(
    parameter bit HAS_LOCK = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_out,
    input logic       pll_on,
    input logic       busy,
    input logic       lock_err,
    input logic       lock_in,
    input logic [7:0] l_low
);
    // Reset release only rises once bypass release was already set.
    p_rst_after_byp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_out[2]) |-> $past(mode_out[1]));

    // Output enable only rises on top of both other bits.
    p_outen_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_out[0]) |-> ($past(mode_out[2]) && $past(mode_out[1])));

    // With a lock input, output enable needs lock sampled high.
    p_outen_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_LOCK && $rose(mode_out[0])) |-> $past(lock_in));

    // Dropping bypass release always drops all three bits together.
    p_off_atomic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_out[1]) |-> (mode_out == 3'b000));

    // Fully-on flag tracks the three mode bits.
    p_on_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_on == (mode_out == 3'b111));

    // Multiplier only changes with the PLL fully off.
    p_l_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l_low) |-> (mode_out == 3'b000));

    // Lock error leaves the PLL off and the sequencer idle.
    p_err_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_err) |-> (mode_out == 3'b000 && !busy));

    // Bypass release happens inside a busy sequence.
    p_byp_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_out[1]) |-> busy);
endmodule

bind pll_mode_sequencer pll_seq_chk #(.HAS_LOCK(HAS_LOCK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_out (mode_out),
    .pll_on   (pll_on),
    .busy     (busy),
    .lock_err (lock_err),
    .lock_in  (lock_in),
    .l_low    (8'(l_out))
);

// File: tb/tb_pll_mode_sequencer.sv
module tb_pll_mode_sequencer;
    localparam int LOCK_DLY = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  boot_mode = 3'b000;
    logic        cmd_valid = 1'b0;
    logic        cmd_valid_t = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_rate = 16'd0;
    logic        lock_in = 1'b0;
    int          lock_mode = 0;   // 0 delayed model, 1 forced high, 2 forced low
    int          lock_cnt = 0;

    logic [2:0]  mode_out, mode_t;
    logic        pll_on, busy, lock_err, vco_hi, cfg_done;
    logic        pll_on_t, busy_t, lock_err_t, vco_hi_t, cfg_done_t;
    logic [7:0]  l_out, m_out, n_out, l_t, m_t, n_t;
    logic [15:0] cfg_out, droop_out, cfg_t, droop_t;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    pll_mode_sequencer dut (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_rate(cmd_rate), .lock_in(lock_in),
        .mode_out(mode_out), .pll_on(pll_on), .busy(busy), .lock_err(lock_err),
        .l_out(l_out), .vco_hi(vco_hi), .m_out(m_out), .n_out(n_out),
        .cfg_out(cfg_out), .droop_out(droop_out), .cfg_done(cfg_done)
    );

    pll_mode_sequencer #(.HAS_LOCK(1'b0)) dut_t (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cmd_valid(cmd_valid_t),
        .cmd_op(cmd_op), .cmd_rate(cmd_rate), .lock_in(1'b0),
        .mode_out(mode_t), .pll_on(pll_on_t), .busy(busy_t), .lock_err(lock_err_t),
        .l_out(l_t), .vco_hi(vco_hi_t), .m_out(m_t), .n_out(n_t),
        .cfg_out(cfg_t), .droop_out(droop_t), .cfg_done(cfg_done_t)
    );

    // Lock model: lock rises LOCK_DLY cycles after reset release.
    always @(posedge clk) begin
        if (lock_mode == 1) begin
            lock_in <= 1'b1;
        end else if (lock_mode == 2) begin
            lock_in <= 1'b0;
        end else if (mode_out[2]) begin
            lock_cnt <= lock_cnt + 1;
            lock_in  <= (lock_cnt >= LOCK_DLY);
        end else begin
            lock_cnt <= 0;
            lock_in  <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] bm);
        boot_mode = bm;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [1:0] op, input logic [15:0] rate, input bit to_t);
        @(negedge clk);
        cmd_op = op;
        cmd_rate = rate;
        if (to_t) cmd_valid_t = 1'b1; else cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_valid_t = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    // Rows: {op, rate, expected mode, expected L, expected vco}
    localparam logic [29:0] VEC [10] = '{
        {2'd1, 16'd0,    3'b111, 8'd0,  1'b0},
        {2'd1, 16'd0,    3'b111, 8'd0,  1'b0},
        {2'd3, 16'd1200, 3'b111, 8'd48, 1'b1},
        {2'd2, 16'd0,    3'b000, 8'd48, 1'b1},
        {2'd3, 16'd800,  3'b000, 8'd32, 1'b0},
        {2'd3, 16'd1000, 3'b000, 8'd40, 1'b0},
        {2'd3, 16'd1025, 3'b000, 8'd41, 1'b1},
        {2'd1, 16'd0,    3'b111, 8'd41, 1'b1},
        {2'd3, 16'd999,  3'b111, 8'd39, 1'b0},
        {2'd2, 16'd0,    3'b000, 8'd39, 1'b0}
    };
    string row_tag [10] = '{"R1 on", "R6 ignored on", "R9 running retune", "R4 off",
                            "R8 idle retune", "R8 band edge", "R8 above edge",
                            "R2 on after retune", "R9 retune floor", "R4 off again"};

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int n2;
        int g;
        // Reset state, sampled while reset is held (R5, R7)
        boot_mode = 3'b000;
        repeat (3) @(negedge clk);
        chk(mode_out == 3'b000, "R5 reset mode", mode_out, 0);
        chk(!pll_on && !busy && !lock_err, "R5 reset flags", {pll_on, busy, lock_err}, 0);
        chk(!cfg_done && n_out == 8'd0, "R7 reset cfg", cfg_done, 0);
        do_reset(3'b000);

        // First switch-on: programming step and exact timings (R7, R1, R2)
        pulse(2'd1, 16'd0, 1'b0);
        n = 1;
        while (!mode_out[1] && n < 50) begin @(negedge clk); n++; end
        chk(n == 3, "R7 first on latency", n, 3);
        chk(cfg_done && m_out == 8'd0 && n_out == 8'd1, "R7 programmed m/n", n_out, 1);
        chk(cfg_out == 16'h0A5C && droop_out == 16'h0108, "R7 cfg/droop", cfg_out, 16'h0A5C);
        g = 0;
        while (!mode_out[2] && g < 100) begin @(negedge clk); g++; end
        chk(g == 20, "R1 settle gap", g, 20);
        while (!lock_in && g < 500) begin
            @(negedge clk);
            g++;
            if (!lock_in) chk(!mode_out[0], "R2 no outen before lock", mode_out[0], 0);
        end
        chk(!mode_out[0], "R2 outen same cycle as lock", mode_out[0], 0);
        @(negedge clk);
        chk(mode_out == 3'b111 && pll_on, "R2 outen after lock", mode_out, 7);
        wait_idle();
        pulse(2'd2, 16'd0, 1'b0);
        pulse(2'd1, 16'd0, 1'b0);
        n2 = 1;
        while (!mode_out[1] && n2 < 50) begin @(negedge clk); n2++; end
        chk(n2 == 2, "R7 no reprogram latency", n2, 2);
        wait_idle();
        pulse(2'd2, 16'd0, 1'b0);

        // Vector table walk (R4, R5, R6, R8, R9)
        for (int i = 0; i < 10; i++) begin
            pulse(VEC[i][29:28], VEC[i][27:12], 1'b0);
            if (VEC[i][29:28] == 2'd1 && i == 1)
                chk(!busy, "R6 on while on no busy", busy, 0);
            if (VEC[i][29:28] == 2'd3 && VEC[i][11:9] == 3'b000)
                chk(!busy, "R9 idle retune no busy", busy, 0);
            wait_idle();
            chk(mode_out == VEC[i][11:9], row_tag[i], mode_out, VEC[i][11:9]);
            chk(l_out == VEC[i][8:1], row_tag[i], l_out, VEC[i][8:1]);
            chk(vco_hi == VEC[i][0], row_tag[i], vco_hi, VEC[i][0]);
            chk(pll_on == (VEC[i][11:9] == 3'b111), "R5 on flag", pll_on, VEC[i][11:9] == 3'b111);
        end

        // Commands during busy are dropped (R12)
        pulse(2'd1, 16'd0, 1'b0);
        repeat (4) @(negedge clk);
        chk(busy, "R12 busy mid sequence", busy, 1);
        pulse(2'd2, 16'd0, 1'b0);
        chk(busy, "R12 still busy", busy, 1);
        wait_idle();
        chk(mode_out == 3'b111, "R12 off while busy ignored", mode_out, 7);
        pulse(2'd2, 16'd0, 1'b0);

        // Lock watchdog (R11)
        lock_mode = 2;
        pulse(2'd1, 16'd0, 1'b0);
        wait_idle();
        chk(mode_out == 3'b000 && lock_err, "R11 watchdog off", {lock_err, mode_out}, 8);
        lock_mode = 0;
        pulse(2'd1, 16'd0, 1'b0);
        chk(!lock_err, "R11 error cleared", lock_err, 0);
        wait_idle();
        chk(mode_out == 3'b111, "R11 recovers", mode_out, 7);

        // Timed lock variant (R3)
        pulse(2'd1, 16'd0, 1'b1);
        g = 0;
        while (!mode_t[2] && g < 200) begin @(negedge clk); g++; end
        g = 0;
        while (!mode_t[0] && g < 400) begin @(negedge clk); g++; end
        chk(g == 120, "R3 timed lock gap", g, 120);
        chk(mode_t == 3'b111 && !busy_t, "R3 timed on", mode_t, 7);

        // Boot checks (R10)
        lock_mode = 2;
        do_reset(3'b111);
        wait_idle();
        chk(mode_out == 3'b000, "R10 unlocked boot off", mode_out, 0);
        chk(cfg_done && n_out == 8'd1, "R10 unlocked boot programmed", cfg_done, 1);
        lock_mode = 1;
        do_reset(3'b111);
        wait_idle();
        chk(mode_out == 3'b111 && pll_on, "R10 locked boot stays on", mode_out, 7);
        chk(!cfg_done, "R10 locked boot no programming", cfg_done, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule